// File: doc/BRIEF.md
# Multi-Level Shift-Keying Profile Modulator

This block sits ahead of a direct digital synthesis core and chooses the frequency tuning word, phase offset and amplitude scale that the core uses. It stores a base word for each of the three quantities, plus a bank of fifteen further profile words. A set of external profile pins then picks one of up to sixteen profiles, so the synthesized output can be keyed among 2, 4, 8 or 16 levels of frequency, phase or amplitude.

A two-bit mode field chooses which quantity is keyed. The two quantities that are not keyed stay at their base values. A two-bit level field sets how many low profile pins take part in the choice. While the auxiliary synthesis channels are running, keying is not allowed and the block holds profile 0. In frequency or phase keying mode, the amplitude can be ramped up or down one step per cycle through a 10-bit scale register. Software fills all the words through a plain address, data and write-enable port.

Top module: `skmod_top`

## Requirements
- R1: `key_levels` sets how many profile pins are used. 0 uses pin 0 only (2 levels), 1 uses pins 1:0, 2 uses pins 2:0 and 3 uses pins 3:0 (16 levels). Pins above the selected ones have no effect on the active profile.
- R2: `key_mode` picks the keyed quantity. 2'b00 means no keying, 2'b01 keys frequency, 2'b10 keys phase and 2'b11 keys amplitude.
- R3: Profile 0 comes from the base registers: frequency at address 0x00, phase at 0x01 (low 14 data bits) and amplitude at 0x02 (low 10 data bits). Profile k, for k from 1 to 15, is the 32-bit register at address 0x10+k. Phase uses its low 14 bits and amplitude uses its low 10 bits. Writes to any other address change nothing.
- R4: The outputs for the quantities that are not keyed equal their base register values.
- R5: While `aux_en` is high, the active profile is 0 whatever the pins show.
- R6: A change on the profile pins reaches the outputs exactly two clock edges later. After one edge, the outputs still show the old profile.
- R7: In frequency or phase mode, `amp_o` comes from a ramp scale. While `ramp_en` is high, the scale moves up by one (when `ramp_up` is 1) or down by one each cycle. It saturates at 1023 and at 0. While the mode is neither frequency nor phase, the scale is loaded with the base amplitude.
- R8: `ramp_en` and `ramp_up` have no effect in no-keying mode or amplitude mode.
- R9: After reset, all stored words and the synchronizer are zero, so all outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synchronization clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| key_mode | input | 2 | Keyed quantity select |
| key_levels | input | 2 | Keying level count select |
| aux_en | input | 1 | Auxiliary channels active; forces profile 0 |
| prof_pins | input | 4 | Asynchronous profile select pins |
| ramp_en | input | 1 | Amplitude ramp step enable |
| ramp_up | input | 1 | Ramp direction, 1 = up |
| ftw_o | output | 32 | Frequency tuning word |
| pow_o | output | 14 | Phase offset word |
| amp_o | output | 10 | Amplitude scale |

## Verification
The bench builds the block with its default parameters: four profile pins, sixteen profiles, and 32/14/10-bit words. At that size, every mode, every level setting and every pin pattern can be swept in full, with the expected word for each case worked out from the masked pin value. The 10-bit scale is small enough that a ramp can be driven across its whole range, from the top clamp down to the bottom clamp, cycle by cycle.

// File: rtl/skmod_pkg.sv
package skmod_pkg;

    typedef enum logic [1:0] {
        KEY_NONE  = 2'b00,
        KEY_FREQ  = 2'b01,
        KEY_PHASE = 2'b10,
        KEY_AMP   = 2'b11
    } key_mode_e;

endpackage

// File: rtl/skmod_pin_sync.sv
module skmod_pin_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] pins_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pins_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pins_o = sync_q.s2;

endmodule

// File: rtl/skmod_regs.sv
module skmod_regs #(
    parameter int DATA_W = 32,
    parameter int POW_W  = 14,
    parameter int AMP_W  = 10,
    parameter int PIN_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PIN_N:0]    wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PIN_N-1:0]  rd_idx,
    output logic [DATA_W-1:0] base_ftw,
    output logic [POW_W-1:0]  base_pow,
    output logic [AMP_W-1:0]  base_amp,
    output logic [DATA_W-1:0] prof_word
);

    localparam int ADDR_W   = PIN_N + 1;
    localparam int NPROF    = 1 << PIN_N;
    localparam int ADDR_FTW = 0;
    localparam int ADDR_POW = 1;
    localparam int ADDR_AMP = 2;

    typedef struct packed {
        logic [DATA_W-1:0]                ftw;
        logic [POW_W-1:0]                 pow;
        logic [AMP_W-1:0]                 amp;
        logic [NPROF-1:1][DATA_W-1:0]     bank;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_FTW)) regs_d.ftw = wr_data;
            if (wr_addr == ADDR_W'(ADDR_POW)) regs_d.pow = wr_data[POW_W-1:0];
            if (wr_addr == ADDR_W'(ADDR_AMP)) regs_d.amp = wr_data[AMP_W-1:0];
            for (int k = 1; k < NPROF; k++) begin
                if (wr_addr == ADDR_W'(NPROF + k)) regs_d.bank[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        prof_word = '0;
        for (int k = 1; k < NPROF; k++) begin
            if (rd_idx == PIN_N'(k)) prof_word = regs_q.bank[k];
        end
    end

    assign base_ftw = regs_q.ftw;
    assign base_pow = regs_q.pow;
    assign base_amp = regs_q.amp;

endmodule

// File: rtl/skmod_ramp.sv
module skmod_ramp #(
    parameter int AMP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ramp_ok,
    input  logic             ramp_en,
    input  logic             ramp_up,
    input  logic [AMP_W-1:0] load_val,
    output logic [AMP_W-1:0] scale_o
);

    localparam logic [AMP_W-1:0] SCALE_MAX = {AMP_W{1'b1}};

    typedef struct packed {
        logic [AMP_W-1:0] scale;
    } ramp_t;

    ramp_t ramp_d, ramp_q;

    always_comb begin
        ramp_d = ramp_q;
        if (!ramp_ok) begin
            ramp_d.scale = load_val;
        end else if (ramp_en) begin
            if (ramp_up) begin
                if (ramp_q.scale != SCALE_MAX) ramp_d.scale = ramp_q.scale + 1'b1;
            end else begin
                if (ramp_q.scale != '0) ramp_d.scale = ramp_q.scale - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ramp_q <= '0;
        else        ramp_q <= ramp_d;
    end

    assign scale_o = ramp_q.scale;

endmodule

// File: rtl/skmod_top.sv
module skmod_top
    import skmod_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int POW_W  = 14,
    parameter int AMP_W  = 10,
    parameter int PIN_N  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [PIN_N:0]             wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [1:0]                 key_mode,
    input  logic [$clog2(PIN_N)-1:0]   key_levels,
    input  logic                       aux_en,
    input  logic [PIN_N-1:0]           prof_pins,
    input  logic                       ramp_en,
    input  logic                       ramp_up,
    output logic [DATA_W-1:0]          ftw_o,
    output logic [POW_W-1:0]           pow_o,
    output logic [AMP_W-1:0]           amp_o
);

    typedef struct packed {
        logic [DATA_W-1:0] ftw;
        logic [POW_W-1:0]  pow;
        logic [AMP_W-1:0]  amp;
    } out_t;

    key_mode_e          mode;
    logic [PIN_N-1:0]   pins_sync;
    logic [PIN_N-1:0]   pin_mask;
    logic [PIN_N-1:0]   idx;
    logic               keyed;
    logic               ramp_ok;
    logic [DATA_W-1:0]  base_ftw;
    logic [POW_W-1:0]   base_pow;
    logic [AMP_W-1:0]   base_amp;
    logic [DATA_W-1:0]  prof_word;
    logic [AMP_W-1:0]   ramp_scale;
    out_t               out_d;

    assign mode = key_mode_e'(key_mode);

    skmod_pin_sync #(.W(PIN_N)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (prof_pins),
        .pins_o (pins_sync)
    );

    always_comb begin
        for (int k = 0; k < PIN_N; k++) begin
            pin_mask[k] = (k <= int'(key_levels));
        end
        idx     = aux_en ? '0 : (pins_sync & pin_mask);
        keyed   = (idx != '0);
        ramp_ok = (mode == KEY_FREQ) || (mode == KEY_PHASE);
    end

    skmod_regs #(
        .DATA_W (DATA_W),
        .POW_W  (POW_W),
        .AMP_W  (AMP_W),
        .PIN_N  (PIN_N)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_idx    (idx),
        .base_ftw  (base_ftw),
        .base_pow  (base_pow),
        .base_amp  (base_amp),
        .prof_word (prof_word)
    );

    skmod_ramp #(.AMP_W(AMP_W)) ramp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ramp_ok  (ramp_ok),
        .ramp_en  (ramp_en),
        .ramp_up  (ramp_up),
        .load_val (base_amp),
        .scale_o  (ramp_scale)
    );

    always_comb begin
        out_d.ftw = base_ftw;
        out_d.pow = base_pow;
        out_d.amp = base_amp;
        unique case (mode)
            KEY_FREQ:  if (keyed) out_d.ftw = prof_word;
            KEY_PHASE: if (keyed) out_d.pow = prof_word[POW_W-1:0];
            KEY_AMP:   if (keyed) out_d.amp = prof_word[AMP_W-1:0];
            default:   ;
        endcase
        if (ramp_ok) out_d.amp = ramp_scale;
    end

    assign ftw_o = out_d.ftw;
    assign pow_o = out_d.pow;
    assign amp_o = out_d.amp;

endmodule

// File: rtl/skmod_chk.sv
module skmod_chk #(
    parameter int DATA_W = 32,
    parameter int POW_W  = 14,
    parameter int AMP_W  = 10,
    parameter int PIN_N  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               key_mode,
    input logic [$clog2(PIN_N)-1:0] key_levels,
    input logic                     aux_en,
    input logic [PIN_N-1:0]         prof_pins,
    input logic                     ramp_en,
    input logic                     ramp_up,
    input logic [PIN_N-1:0]         idx,
    input logic [DATA_W-1:0]        base_ftw,
    input logic [POW_W-1:0]         base_pow,
    input logic [AMP_W-1:0]         base_amp,
    input logic [DATA_W-1:0]        ftw_o,
    input logic [POW_W-1:0]         pow_o,
    input logic [AMP_W-1:0]         amp_o
);

    localparam logic [AMP_W-1:0] SCALE_MAX = {AMP_W{1'b1}};

    logic [1:0]       seen_q;
    logic [PIN_N-1:0] lvl_mask;
    logic             ramp_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              seen_q <= '0;
        else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
    end

    always_comb begin
        for (int k = 0; k < PIN_N; k++) lvl_mask[k] = (k <= int'(key_levels));
        ramp_mode = (key_mode == 2'b01) || (key_mode == 2'b10);
    end

    assert_unkeyed_ftw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_mode != 2'b01) |-> (ftw_o == base_ftw));

    assert_unkeyed_pow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_mode != 2'b10) |-> (pow_o == base_pow));

    assert_aux_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        aux_en |-> (ftw_o == base_ftw && pow_o == base_pow));

    assert_pin_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= 2'd2 && !aux_en) |-> (idx == ($past(prof_pins, 2) & lvl_mask)));

    assert_ramp_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != 2'd0 && ramp_mode && $past(ramp_mode) && $past(ramp_en) && $past(ramp_up)
         && $past(amp_o) != SCALE_MAX) |-> (amp_o == $past(amp_o) + 1'b1));

    assert_ramp_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != 2'd0 && ramp_mode && $past(ramp_mode) && $past(ramp_en) && !$past(ramp_up)
         && $past(amp_o) != '0) |-> (amp_o == $past(amp_o) - 1'b1));

    assert_ramp_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != 2'd0 && ramp_mode && $past(ramp_mode) && $past(ramp_en) && $past(ramp_up)
         && $past(amp_o) == SCALE_MAX) |-> (amp_o == SCALE_MAX));

    assert_ramp_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (key_mode == 2'b00) |-> (amp_o == base_amp));

endmodule

bind skmod_top skmod_chk #(
    .DATA_W (DATA_W),
    .POW_W  (POW_W),
    .AMP_W  (AMP_W),
    .PIN_N  (PIN_N)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_mode   (key_mode),
    .key_levels (key_levels),
    .aux_en     (aux_en),
    .prof_pins  (prof_pins),
    .ramp_en    (ramp_en),
    .ramp_up    (ramp_up),
    .idx        (idx),
    .base_ftw   (base_ftw),
    .base_pow   (base_pow),
    .base_amp   (base_amp),
    .ftw_o      (ftw_o),
    .pow_o      (pow_o),
    .amp_o      (amp_o)
);

// File: tb/skmod_tb.sv
module skmod_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  key_mode = '0;
    logic [1:0]  key_levels = '0;
    logic        aux_en = 1'b0;
    logic [3:0]  prof_pins = '0;
    logic        ramp_en = 1'b0;
    logic        ramp_up = 1'b0;
    logic [31:0] ftw_o;
    logic [13:0] pow_o;
    logic [9:0]  amp_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] prof_m [16];
    logic [31:0] bftw;
    logic [13:0] bpow;
    logic [9:0]  bamp;

    always #(CLK_PERIOD/2) clk = ~clk;

    skmod_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .key_mode   (key_mode),
        .key_levels (key_levels),
        .aux_en     (aux_en),
        .prof_pins  (prof_pins),
        .ramp_en    (ramp_en),
        .ramp_up    (ramp_up),
        .ftw_o      (ftw_o),
        .pow_o      (pow_o),
        .amp_o      (amp_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int idx;
        logic [31:0] ef;
        logic [13:0] ep;
        logic [9:0]  ea;
        int v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 ftw", ftw_o, 32'h0);
        chk("R9 pow", {18'h0, pow_o}, 32'h0);
        chk("R9 amp", {22'h0, amp_o}, 32'h0);
        key_mode = 2'b01; key_levels = 2'd3; prof_pins = 4'd9;
        repeat (2) @(negedge clk);
        chk("R9 bank zero", ftw_o, 32'h0);
        key_mode = 2'b00; prof_pins = 4'd0;

        // R3: fill base and profile registers, narrow words from low bits
        bftw = 32'hC0FF_EE11;
        bpow = 14'h1555;
        bamp = 10'h2AA;
        wr(5'h00, bftw);
        wr(5'h01, 32'hFFFF_9555);
        wr(5'h02, 32'hFFFF_F6AA);
        prof_m[0] = 32'h0;
        for (int k = 1; k < 16; k++) begin
            prof_m[k] = (32'(k) * 32'h9E37_79B9) ^ 32'h0F00_0000;
            wr(5'(16 + k), prof_m[k]);
        end
        @(negedge clk);
        chk("R3 base phase low bits", {18'h0, pow_o}, {18'h0, bpow});
        chk("R3 base amp low bits", {22'h0, amp_o}, {22'h0, bamp});
        chk("R3 base freq", ftw_o, bftw);

        // R1 R2 R4: exhaustive sweep of mode x level x pins
        for (int m = 1; m < 4; m++) begin
            for (int l = 0; l < 4; l++) begin
                for (int p = 0; p < 16; p++) begin
                    key_mode = 2'(m); key_levels = 2'(l); prof_pins = 4'(p);
                    repeat (2) @(negedge clk);
                    idx = p & ((1 << (l + 1)) - 1);
                    ef = (m == 1 && idx != 0) ? prof_m[idx] : bftw;
                    ep = (m == 2 && idx != 0) ? prof_m[idx][13:0] : bpow;
                    ea = (m == 3 && idx != 0) ? prof_m[idx][9:0] : bamp;
                    chk("R1 R2 R4 ftw", ftw_o, ef);
                    chk("R1 R2 R4 pow", {18'h0, pow_o}, {18'h0, ep});
                    chk("R1 R2 R4 amp", {22'h0, amp_o}, {22'h0, ea});
                end
            end
        end

        // R6: two-edge latency
        key_mode = 2'b01; key_levels = 2'd3; prof_pins = 4'd0;
        repeat (2) @(negedge clk);
        prof_pins = 4'd5;
        @(negedge clk);
        chk("R6 after one edge", ftw_o, bftw);
        @(negedge clk);
        chk("R6 after two edges", ftw_o, prof_m[5]);

        // R5: auxiliary channels force profile 0
        aux_en = 1'b1; prof_pins = 4'd7;
        repeat (3) @(negedge clk);
        chk("R5 aux holds ftw", ftw_o, bftw);
        key_mode = 2'b10;
        #1;
        chk("R5 aux holds pow", {18'h0, pow_o}, {18'h0, bpow});
        key_mode = 2'b01;
        aux_en = 1'b0;
        @(negedge clk);
        chk("R5 released", ftw_o, prof_m[7]);

        // R3: writes to unmapped addresses change nothing
        wr(5'h03, 32'hDEAD_BEEF);
        wr(5'h0F, 32'hDEAD_BEEF);
        wr(5'h10, 32'hDEAD_BEEF);
        for (int p = 0; p < 16; p++) begin
            prof_pins = 4'(p);
            repeat (2) @(negedge clk);
            chk("R3 unmapped write freq", ftw_o, (p == 0) ? bftw : prof_m[p]);
        end
        key_mode = 2'b00;
        #1;
        chk("R3 unmapped write pow", {18'h0, pow_o}, {18'h0, bpow});
        chk("R3 unmapped write amp", {22'h0, amp_o}, {22'h0, bamp});

        // R7: ramp up with clamp, then down to zero with clamp
        bamp = 10'h3FA;
        wr(5'h02, 32'h0000_03FA);
        prof_pins = 4'd0;
        @(negedge clk);
        key_mode = 2'b01; ramp_en = 1'b1; ramp_up = 1'b1;
        for (int n = 0; n < 10; n++) begin
            #1;
            v = (32'h3FA + n > 1023) ? 1023 : 32'h3FA + n;
            chk("R7 ramp up", {22'h0, amp_o}, 32'(v));
            @(negedge clk);
        end
        ramp_up = 1'b0;
        for (int n = 0; n < 1030; n++) begin
            #1;
            v = (1023 - n < 0) ? 0 : 1023 - n;
            chk("R7 ramp down", {22'h0, amp_o}, 32'(v));
            @(negedge clk);
        end
        ramp_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 hold at zero", {22'h0, amp_o}, 32'h0);

        // R7: phase mode also ramps, after reload from base
        key_mode = 2'b00;
        @(negedge clk);
        key_mode = 2'b10; ramp_en = 1'b1; ramp_up = 1'b0;
        #1;
        chk("R7 reload base", {22'h0, amp_o}, 32'h3FA);
        @(negedge clk);
        chk("R7 phase ramp step", {22'h0, amp_o}, 32'h3F9);

        // R8: ramp ignored in amplitude and no-keying modes
        key_mode = 2'b11; ramp_up = 1'b1; prof_pins = 4'd6;
        repeat (2) @(negedge clk);
        for (int n = 0; n < 4; n++) begin
            chk("R8 amp mode ignores ramp", {22'h0, amp_o}, {22'h0, prof_m[6][9:0]});
            @(negedge clk);
        end
        key_mode = 2'b00;
        for (int n = 0; n < 4; n++) begin
            #1;
            chk("R8 none mode ignores ramp", {22'h0, amp_o}, 32'h3FA);
            @(negedge clk);
        end
        ramp_en = 1'b0;

        finish_run();
    end

endmodule